// File: doc/BRIEF.md
# Rename Buffer Write-Back Scheduler

This block holds the rename entries of an out-of-order core from the point where an instruction is given a destination entry until that entry's result has been copied into the architectural register file. Before its instruction completes, an entry is a private holding place for a speculative result. Once the completion logic reports the instruction as completed, the same entry becomes a write-back buffer. Write-back is a stage of its own after completion, limited by the register file's write ports, so an instruction may complete before its result exists (a load that missed in the cache, for instance). Its entry then waits and drains once the data arrives.

Dispatch claims an entry by tag. The execution units deliver a result by tag. The completion logic announces completed instructions one per cycle, in program order, with their destination register. A flush throws away every entry whose instruction has not completed. Each cycle the scheduler looks at the oldest completed entries in completion order. Through its two registered write ports it copies up to two of them whose results are present, and it reports every released entry on a one-hot free mask, so that dispatch can hand the entry out again.

Top module: `rbwb_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, both write-back ports are invalid and the free mask is all zero; afterwards every entry is free and no completion is pending.
- R2: No more than two register-file writes occur per cycle, and write port 1 is valid only in a cycle where write port 0 is also valid.
- R3: A completion notice for an entry whose result is already present, with no older completed entry pending, produces a write on port 0 on the clock edge after the edge that samples the notice, carrying the notice's destination register and the entry's result.
- R4: A completed entry whose result is missing causes no write while it waits; once it is the oldest pending entry, it is written on the clock edge after the edge that samples its result.
- R5: Writes leave in the order of the completion notices, and port 0 always carries the older of two writes in one cycle. The oldest pending entry lacking its result holds back every younger completed entry, even ones whose data is present.
- R6: Free-mask bit t (bit index equals entry tag) is set for exactly the cycle in which entry t's write appears on a port; the entry may then be claimed again and behaves as new.
- R7: A flush releases every claimed entry whose instruction has not completed and sets its free-mask bits on the edge that samples the flush. Completed entries survive the flush and are still written back later.
- R8: A result delivered to an entry that is not claimed is discarded: if the entry is claimed and completed later, it waits for a fresh result.
- R9: When the two oldest pending entries both hold results, both are written in the same cycle, the older on port 0 and the younger on port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Dispatch claims an entry this cycle |
| alloc_tag | input | TAG_W | Tag of the claimed entry |
| res_vld | input | 1 | Execution delivers a result this cycle |
| res_tag | input | TAG_W | Entry receiving the result |
| res_data | input | DATA_W | Result value |
| cmpl_vld | input | 1 | Completion notice this cycle |
| cmpl_tag | input | TAG_W | Entry of the completed instruction |
| cmpl_dest | input | REG_AW | Architectural destination register |
| flush | input | 1 | Discard all entries not yet completed |
| wb_vld | output | NUM_WB | Per-port register-file write enable, bit 0 = port 0 |
| wb_addr | output | NUM_WB x REG_AW | Per-port destination register |
| wb_data | output | NUM_WB x DATA_W | Per-port write data |
| free_mask | output | NUM_ENT | One-hot per entry, set on the cycle the entry is released |

## Verification
On every cycle, the assertions hold that port 1 never writes without port 0, that every write is matched by a released entry, that only a completed entry holding a result is released, that a flush never removes a completed entry, and that the completion queue neither overflows nor pops more than it holds. Write ordering, the exact latency from a notice or a late result to the port, the values on the ports, blocking behind a missing result, and the discarding of stray results after a flush depend on whole sequences of events. Only the bench scenarios show these, sweeping every ordered pair of entries through three arrival orders.

// File: rtl/rbwb_pkg.sv
package rbwb_pkg;
  // life cycle of one rename entry
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,  // unclaimed
    ENT_SPEC = 2'd1,  // claimed, instruction not yet completed
    ENT_DONE = 2'd2   // completed, waiting for write-back
  } ent_state_e;
endpackage

// File: rtl/rbwb_data_ram.sv
module rbwb_data_ram #(
  parameter int NUM_ENT = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_RD  = 2,
  localparam int TAG_W  = $clog2(NUM_ENT)
) (
  input  logic                          clk,
  input  logic                          we,
  input  logic [TAG_W-1:0]              waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_RD-1:0][TAG_W-1:0]  raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NUM_ENT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // one registered read port per write-back port
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/rbwb_cmpl_queue.sv
module rbwb_cmpl_queue #(
  parameter int NUM_ENT = 8,
  parameter int NUM_WB  = 2,
  localparam int TAG_W  = $clog2(NUM_ENT),
  localparam int CW     = TAG_W + 1,
  localparam int PCW    = $clog2(NUM_WB + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [TAG_W-1:0]             push_tag,
  input  logic [PCW-1:0]               pop_cnt,
  output logic [NUM_WB-1:0][TAG_W-1:0] peek_tag,
  output logic [CW-1:0]                cnt
);
  logic [TAG_W-1:0] slots [NUM_ENT];
  logic [TAG_W-1:0] head, tail;

  always_ff @(posedge clk) begin
    if (push) slots[tail] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= tail + TAG_W'(1);
      head <= head + TAG_W'(pop_cnt);
      cnt  <= cnt + CW'(push) - CW'(pop_cnt);
    end
  end

  for (genvar i = 0; i < NUM_WB; i++) begin : g_peek
    assign peek_tag[i] = slots[head + TAG_W'(i)];
  end

  // R5: completion order is kept only if the queue never wraps onto itself
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CW'(NUM_ENT)) || (pop_cnt != '0));

  // R2: the scheduler never drains more than it holds
  assert_pop_bound_R2: assert property (@(posedge clk) disable iff (rst)
    CW'(pop_cnt) <= cnt);
endmodule

// File: rtl/rbwb_entry_table.sv
module rbwb_entry_table
  import rbwb_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int REG_AW  = 5,
  localparam int TAG_W  = $clog2(NUM_ENT)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_vld,
  input  logic [TAG_W-1:0]              alloc_tag,
  input  logic                          res_vld,
  input  logic [TAG_W-1:0]              res_tag,
  input  logic                          cmpl_vld,
  input  logic [TAG_W-1:0]              cmpl_tag,
  input  logic [REG_AW-1:0]             cmpl_dest,
  input  logic                          flush,
  input  logic [NUM_ENT-1:0]            rel_mask,
  output logic [NUM_ENT-1:0]            ready_vec,
  output logic [NUM_ENT-1:0]            kill_mask,
  output logic [NUM_ENT-1:0][REG_AW-1:0] dest_arr
);
  ent_state_e       state [NUM_ENT];
  logic [NUM_ENT-1:0] has_data;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic hit_alloc, hit_res, hit_cmpl;
    assign hit_alloc = alloc_vld && (alloc_tag == TAG_W'(e));
    assign hit_res   = res_vld   && (res_tag   == TAG_W'(e));
    assign hit_cmpl  = cmpl_vld  && (cmpl_tag  == TAG_W'(e)) && (state[e] == ENT_SPEC);

    // a completion in the flush cycle still counts: that instruction is older
    assign kill_mask[e] = flush && (state[e] == ENT_SPEC) && !hit_cmpl;
    assign ready_vec[e] = (state[e] == ENT_DONE) && has_data[e];

    always_ff @(posedge clk) begin
      if (rst) begin
        state[e]    <= ENT_FREE;
        has_data[e] <= 1'b0;
      end else if (rel_mask[e]) begin
        state[e]    <= ENT_FREE;
        has_data[e] <= 1'b0;
      end else if (hit_alloc) begin
        state[e]    <= ENT_SPEC;
        has_data[e] <= 1'b0;
      end else begin
        if (hit_cmpl)          state[e] <= ENT_DONE;
        else if (kill_mask[e]) state[e] <= ENT_FREE;
        if (hit_res && (state[e] != ENT_FREE) && !kill_mask[e]) has_data[e] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_cmpl) dest_arr[e] <= cmpl_dest;
    end

    // R4: only a completed entry that holds its result may be written back
    assert_release_ready_R4: assert property (@(posedge clk) disable iff (rst)
      rel_mask[e] |-> (state[e] == ENT_DONE) && has_data[e]);

    // R7: a flush never removes a completed entry
    assert_flush_keeps_done_R7: assert property (@(posedge clk) disable iff (rst)
      (flush && (state[e] == ENT_DONE) && !rel_mask[e]) |=> (state[e] == ENT_DONE));
  end
endmodule

// File: rtl/rbwb_sched.sv
module rbwb_sched #(
  parameter int NUM_ENT = 8,
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter int NUM_WB  = 2,
  localparam int TAG_W  = $clog2(NUM_ENT),
  localparam int CW     = TAG_W + 1,
  localparam int PCW    = $clog2(NUM_WB + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          alloc_vld,
  input  logic [TAG_W-1:0]              alloc_tag,
  input  logic                          res_vld,
  input  logic [TAG_W-1:0]              res_tag,
  input  logic [DATA_W-1:0]             res_data,
  input  logic                          cmpl_vld,
  input  logic [TAG_W-1:0]              cmpl_tag,
  input  logic [REG_AW-1:0]             cmpl_dest,
  input  logic                          flush,
  output logic [NUM_WB-1:0]             wb_vld,
  output logic [NUM_WB-1:0][REG_AW-1:0] wb_addr,
  output logic [NUM_WB-1:0][DATA_W-1:0] wb_data,
  output logic [NUM_ENT-1:0]            free_mask
);
  logic [NUM_WB-1:0][TAG_W-1:0]  peek_tag;
  logic [CW-1:0]                 q_cnt;
  logic [NUM_ENT-1:0]            ready_vec, kill_mask, rel_mask;
  logic [NUM_ENT-1:0][REG_AW-1:0] dest_arr;
  logic [NUM_WB-1:0]             sel;
  logic [PCW-1:0]                pop_cnt;

  rbwb_cmpl_queue #(.NUM_ENT(NUM_ENT), .NUM_WB(NUM_WB)) u_queue (
    .clk(clk), .rst(rst),
    .push(cmpl_vld), .push_tag(cmpl_tag),
    .pop_cnt(pop_cnt), .peek_tag(peek_tag), .cnt(q_cnt)
  );

  rbwb_entry_table #(.NUM_ENT(NUM_ENT), .REG_AW(REG_AW)) u_table (
    .clk(clk), .rst(rst),
    .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
    .res_vld(res_vld), .res_tag(res_tag),
    .cmpl_vld(cmpl_vld), .cmpl_tag(cmpl_tag), .cmpl_dest(cmpl_dest),
    .flush(flush), .rel_mask(rel_mask),
    .ready_vec(ready_vec), .kill_mask(kill_mask), .dest_arr(dest_arr)
  );

  rbwb_data_ram #(.NUM_ENT(NUM_ENT), .DATA_W(DATA_W), .NUM_RD(NUM_WB)) u_ram (
    .clk(clk), .we(res_vld), .waddr(res_tag), .wdata(res_data),
    .raddr(peek_tag), .rdata(wb_data)
  );

  // in-order drain: a port is used only if every older slot is used too
  for (genvar i = 0; i < NUM_WB; i++) begin : g_sel
    if (i == 0) begin : g_first
      assign sel[i] = (q_cnt > CW'(i)) && ready_vec[peek_tag[i]];
    end else begin : g_next
      assign sel[i] = sel[i-1] && (q_cnt > CW'(i)) && ready_vec[peek_tag[i]];
    end
  end

  always_comb begin
    pop_cnt  = '0;
    rel_mask = '0;
    for (int i = 0; i < NUM_WB; i++) begin
      pop_cnt = pop_cnt + PCW'(sel[i]);
      if (sel[i]) rel_mask[peek_tag[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_vld    <= '0;
      free_mask <= '0;
    end else begin
      wb_vld    <= sel;
      free_mask <= rel_mask | kill_mask;
    end
  end

  for (genvar i = 0; i < NUM_WB; i++) begin : g_addr
    always_ff @(posedge clk) begin
      wb_addr[i] <= dest_arr[peek_tag[i]];
    end
    if (i > 0) begin : g_ord
      // R2: higher ports fill only behind lower ones
      assert_port_order_R2: assert property (@(posedge clk) disable iff (rst)
        wb_vld[i] |-> wb_vld[i-1]);
    end
  end

  // R6: every write is accompanied by a released entry
  assert_free_covers_wb_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(free_mask) >= $countones(wb_vld));

  // R1: nothing leaves the block right after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (wb_vld == '0) && (free_mask == '0));
endmodule

// File: tb/rbwb_sched_bench.sv
`timescale 1ns/1ps
module rbwb_sched_bench;
  localparam int NE = 8, DW = 32, AW = 5, NW = 2, TW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic alloc_vld = 0, res_vld = 0, cmpl_vld = 0, flush = 0;
  logic [TW-1:0] alloc_tag = '0, res_tag = '0, cmpl_tag = '0;
  logic [DW-1:0] res_data = '0;
  logic [AW-1:0] cmpl_dest = '0;
  logic [NW-1:0] wb_vld;
  logic [NW-1:0][AW-1:0] wb_addr;
  logic [NW-1:0][DW-1:0] wb_data;
  logic [NE-1:0] free_mask;

  rbwb_sched u_rbwb_sched (
    .clk(clk), .rst(rst),
    .alloc_vld(alloc_vld), .alloc_tag(alloc_tag),
    .res_vld(res_vld), .res_tag(res_tag), .res_data(res_data),
    .cmpl_vld(cmpl_vld), .cmpl_tag(cmpl_tag), .cmpl_dest(cmpl_dest),
    .flush(flush),
    .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_data(wb_data), .free_mask(free_mask)
  );

  int n_chk = 0, n_bad = 0, pair_bad = 0;

  function automatic logic [DW-1:0] data_of(int t, int run);
    return 32'hC0DE_0000 ^ (DW'(run) << 8) ^ (DW'(t) * 32'h0101_0101);
  endfunction
  function automatic logic [AW-1:0] dest_of(int t, int run);
    return AW'((t * 5 + run) % 32);
  endfunction

  task automatic do_alloc(int t);
    alloc_vld = 1; alloc_tag = TW'(t); @(negedge clk); alloc_vld = 0;
  endtask
  task automatic do_res(int t, int run);
    res_vld = 1; res_tag = TW'(t); res_data = data_of(t, run); @(negedge clk); res_vld = 0;
  endtask
  task automatic do_cmpl(int t, int run);
    cmpl_vld = 1; cmpl_tag = TW'(t); cmpl_dest = dest_of(t, run); @(negedge clk); cmpl_vld = 0;
  endtask
  task automatic do_flush();
    flush = 1; @(negedge clk); flush = 0;
  endtask

  // compare both ports and the free mask against the expected writes
  task automatic check_out(input logic [1:0] ev, int t0, int t1, int run,
                           input logic [NE-1:0] extra_free, input string req);
    logic [NE-1:0] ef;
    logic bad;
    ef = extra_free;
    if (ev[0]) ef[t0] = 1'b1;
    if (ev[1]) ef[t1] = 1'b1;
    bad = (wb_vld !== ev) || (free_mask !== ef);
    if (ev[0] && (wb_addr[0] !== dest_of(t0, run) || wb_data[0] !== data_of(t0, run))) bad = 1;
    if (ev[1] && (wb_addr[1] !== dest_of(t1, run) || wb_data[1] !== data_of(t1, run))) bad = 1;
    n_chk++;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got vld=%b free=%b a0=%0d d0=%h a1=%0d d1=%h exp vld=%b free=%b a0=%0d d0=%h a1=%0d d1=%h",
               req, wb_vld, free_mask, wb_addr[0], wb_data[0], wb_addr[1], wb_data[1],
               ev, ef, dest_of(t0, run), data_of(t0, run), dest_of(t1, run), data_of(t1, run));
    end
  endtask

  // R2: port 1 never writes alone
  always @(negedge clk) if (!rst && wb_vld[1] && !wb_vld[0]) pair_bad++;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got running expected finished");
    finish_run();
  end

  initial begin
    int run;
    run = 1;
    repeat (3) @(negedge clk);
    check_out(2'b00, 0, 0, 0, '0, "R1 during reset");
    rst = 0;
    @(negedge clk);
    check_out(2'b00, 0, 0, 0, '0, "R1 after reset");

    // R3: data ready before completion
    do_alloc(0); do_res(0, 900); do_cmpl(0, 900);
    check_out(2'b00, 0, 0, 900, '0, "R3 not before latency");
    @(negedge clk);
    check_out(2'b01, 0, 0, 900, '0, "R3 same-stage write");

    // R4: completion without data
    do_alloc(1); do_cmpl(1, 901);
    repeat (3) begin
      @(negedge clk);
      check_out(2'b00, 0, 0, 901, '0, "R4 waits for data");
    end
    do_res(1, 901);
    @(negedge clk);
    check_out(2'b01, 1, 0, 901, '0, "R4 late data written");

    // sweep of ordered pairs and arrival orders: R5, R6, R9
    for (int a = 0; a < NE; a++) begin
      for (int b = 0; b < NE; b++) begin
        if (a == b) continue;
        for (int v = 0; v < 3; v++) begin
          run++;
          do_alloc(a); do_alloc(b);
          if (v == 0) begin
            do_res(a, run); do_res(b, run);
            do_cmpl(a, run); do_cmpl(b, run);
            check_out(2'b01, a, 0, run, '0, "R5/R6 first single");
            @(negedge clk);
            check_out(2'b01, b, 0, run, '0, "R5/R6 second single");
          end else if (v == 1) begin
            do_cmpl(a, run); do_cmpl(b, run);
            check_out(2'b00, 0, 0, run, '0, "R4 none ready");
            do_res(a, run); @(negedge clk);
            check_out(2'b01, a, 0, run, '0, "R4 older alone");
            do_res(b, run); @(negedge clk);
            check_out(2'b01, b, 0, run, '0, "R4 younger alone");
          end else begin
            do_cmpl(a, run); do_cmpl(b, run);
            do_res(b, run);
            check_out(2'b00, 0, 0, run, '0, "R5 blocked");
            @(negedge clk);
            check_out(2'b00, 0, 0, run, '0, "R5 younger held");
            do_res(a, run); @(negedge clk);
            check_out(2'b11, a, b, run, '0, "R9 pair");
          end
          @(negedge clk);
          check_out(2'b00, 0, 0, run, '0, "R6 idle after drain");
        end
      end
    end

    // R7 / R8: flush
    do_alloc(2); do_alloc(3); do_alloc(4);
    do_cmpl(2, 500);
    do_flush();
    check_out(2'b00, 0, 0, 500, 8'b0001_1000, "R7 flush frees uncompleted");
    do_res(3, 500);
    do_res(2, 500);
    @(negedge clk);
    check_out(2'b01, 2, 0, 500, '0, "R7 completed survives");
    do_alloc(3); do_cmpl(3, 501);
    @(negedge clk);
    check_out(2'b00, 0, 0, 501, '0, "R8 stray result dropped");
    @(negedge clk);
    check_out(2'b00, 0, 0, 501, '0, "R8 still waiting");
    do_res(3, 501);
    @(negedge clk);
    check_out(2'b01, 3, 0, 501, '0, "R8 fresh data written");

    n_chk++;
    if (pair_bad != 0) begin
      n_bad++;
      $display("FAIL R2: port1 alone %0d times expected 0", pair_bad);
    end
    finish_run();
  end
endmodule